// File: doc/BRIEF.md
# Register-Mapped SPI Word FIFO Front End

This block sits between a 32-bit register bus and a serial shift engine of an SPI master. Software sees five word-wide locations: a command word that is passed straight to the shift engine, a status word, a transfer-control word, a transmit FIFO push port and a receive FIFO pop port. Both FIFOs are four words deep by default. A burst moves at most that many words.

To run a burst, software pushes the words to send and sets the direction bits in the command word. It then writes the transfer-control word with the start bit set and the word count minus one in its low half. The block hands words one at a time to the shift engine. It keeps one word in flight and waits for the engine's completion pulse before issuing the next word. Returned words are queued for software. At the end of the burst the block drops busy, raises ready and clears its own start bit. If an interrupt enable matches an active direction, it also holds the interrupt line high until software acknowledges ready.

Top module: `spf_frontend`

## Requirements
- R1: After reset the command and control words read 0, the interrupt is low and status reads 0x0280_0000 (both FIFOs empty). The control word reads back its stored fields: start bit 31, receive-done interrupt enable bit 27, transmit-done interrupt enable bit 26, packed select bit 20, receive trigger bits 19:18, transmit trigger bits 17:16 and count bits 15:0. All other control bits read 0.
- R2: Offset 0x10 pushes into the transmit FIFO, and words reach the shift engine in the order written. A push while the FIFO is full, with no pop in the same cycle, drops the word and sets status bit 26.
- R3: Offset 0x20 pops received words in arrival order. This holds when a pop and an engine delivery fall in the same cycle. A pop while the FIFO is empty returns 0 and sets status bit 27.
- R4: A control write with bit 31 set while idle starts a burst of min(count+1, 4) words, and status bit 31 (busy) reads 1 until the burst ends.
- R5: When the last word of a burst completes, busy clears, status bit 30 (ready) sets and control bit 31 reads 0.
- R6: The interrupt is high exactly while ready is set and either (bit 26 of control and command bit 15) or (bit 27 of control and command bit 14) holds.
- R7: Writing 1 to status bit 30, 27 or 26 clears that flag. Writing 0 leaves it.
- R8: Writing 1 to status bit 29 empties the transmit FIFO, and writing 1 to bit 28 empties the receive FIFO.
- R9: Command bit 15 selects transmit: when it is 0 the engine receives zero words and the transmit FIFO is not popped. Command bit 14 selects receive: when it is 0 returned words are discarded.
- R10: With transmit selected and the transmit FIFO empty, no word is issued to the engine until software pushes one.
- R11: Control writes while busy are ignored.
- R12: Status bits 25, 24, 23 and 22 report receive empty, receive full, transmit empty and transmit full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive FIFO at 0x20) |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| eng_cmd | output | 32 | Command word for the shift engine |
| eng_load | output | 1 | Word offered to the shift engine this cycle |
| eng_tx_word | output | 32 | Word to shift out |
| eng_done | input | 1 | Engine finished the word in flight |
| eng_rx_word | input | 32 | Word shifted in, valid with eng_done |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
The receive FIFO can see a software pop at offset 0x20 and a push from a finished engine word in the same cycle. The same holds for a software push at 0x10 and an engine pop on the transmit side. The bench provokes these collisions by draining the receive FIFO while bursts run, with random engine latencies of zero to five cycles, so that engine deliveries and bus pops coincide. The result is judged by comparing every popped word, in order, against the words the engine model delivered. A lost or duplicated word in a colliding cycle shows up as a data or count mismatch.

// File: rtl/spf_pkg.sv
package spf_pkg;

    localparam int unsigned REG_W  = 32;
    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_CMD  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_TXF  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_RXF  = 8'h20;

    localparam int unsigned ST_BUSY   = 31;
    localparam int unsigned ST_READY  = 30;
    localparam int unsigned ST_TXFLSH = 29;
    localparam int unsigned ST_RXFLSH = 28;
    localparam int unsigned ST_RXUNF  = 27;
    localparam int unsigned ST_TXOVF  = 26;
    localparam int unsigned ST_RXEMP  = 25;
    localparam int unsigned ST_RXFUL  = 24;
    localparam int unsigned ST_TXEMP  = 23;
    localparam int unsigned ST_TXFUL  = 22;

    localparam int unsigned CMD_TXDIR = 15;
    localparam int unsigned CMD_RXDIR = 14;

    typedef enum logic [1:0] {
        BS_IDLE  = 2'd0,
        BS_ISSUE = 2'd1,
        BS_WAIT  = 2'd2
    } burst_state_t;

    typedef struct packed {
        logic        go;
        logic        ie_rx;
        logic        ie_tx;
        logic        pack_sel;
        logic [1:0]  rx_lvl;
        logic [1:0]  tx_lvl;
        logic [15:0] cnt_m1;
    } xfer_ctl_t;

    function automatic xfer_ctl_t word_to_ctl(input logic [REG_W-1:0] w);
        xfer_ctl_t c;
        c.go       = w[31];
        c.ie_rx    = w[27];
        c.ie_tx    = w[26];
        c.pack_sel = w[20];
        c.rx_lvl   = w[19:18];
        c.tx_lvl   = w[17:16];
        c.cnt_m1   = w[15:0];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctl_to_word(input xfer_ctl_t c);
        logic [REG_W-1:0] w;
        w          = '0;
        w[31]      = c.go;
        w[27]      = c.ie_rx;
        w[26]      = c.ie_tx;
        w[20]      = c.pack_sel;
        w[19:18]   = c.rx_lvl;
        w[17:16]   = c.tx_lvl;
        w[15:0]    = c.cnt_m1;
        return w;
    endfunction

    function automatic int unsigned burst_len(input logic [15:0] cnt_m1,
                                              input int unsigned depth);
        int unsigned n;
        n = int'(cnt_m1) + 1;
        return (n > depth) ? depth : n;
    endfunction

endpackage

// File: rtl/spf_fifo.sv
module spf_fifo #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic             push_ok
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wptr, rptr;
    logic [CW-1:0]    fill;
    logic             do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (fill == '0);
    assign full    = (fill == CW'(DEPTH));
    assign do_pop  = pop && !empty && !flush;
    assign push_ok = push && !flush && (!full || do_pop);
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (push_ok) wptr <= step(wptr);
            if (do_pop)  rptr <= step(rptr);
            case ({push_ok, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= push_data;
    end

endmodule

// File: rtl/spf_burst.sv
module spf_burst
    import spf_pkg::*;
#(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CW-1:0]    start_words,
    input  logic             tx_sel,
    input  logic             rx_sel,
    input  logic             tx_empty,
    input  logic [WIDTH-1:0] tx_head,
    input  logic             eng_done,
    input  logic [WIDTH-1:0] eng_rx_word,
    output logic             busy,
    output logic             done,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [WIDTH-1:0] rx_word,
    output logic             eng_load,
    output logic [WIDTH-1:0] eng_tx_word,
    output logic             tx_act,
    output logic             rx_act
);
    burst_state_t state;
    logic [CW-1:0] left;
    logic          can_issue;

    assign busy        = (state != BS_IDLE);
    assign can_issue   = !tx_act || !tx_empty;
    assign eng_load    = (state == BS_ISSUE) && can_issue;
    assign tx_pop      = eng_load && tx_act;
    assign eng_tx_word = tx_act ? tx_head : '0;
    assign rx_push     = (state == BS_WAIT) && eng_done && rx_act;
    assign rx_word     = eng_rx_word;
    assign done        = (state == BS_WAIT) && eng_done && (left == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= BS_IDLE;
            left   <= '0;
            tx_act <= 1'b0;
            rx_act <= 1'b0;
        end else begin
            case (state)
                BS_IDLE: begin
                    if (start) begin
                        state  <= BS_ISSUE;
                        left   <= start_words;
                        tx_act <= tx_sel;
                        rx_act <= rx_sel;
                    end
                end
                BS_ISSUE: begin
                    if (can_issue) state <= BS_WAIT;
                end
                BS_WAIT: begin
                    if (eng_done) begin
                        left  <= left - 1'b1;
                        state <= (left == CW'(1)) ? BS_IDLE : BS_ISSUE;
                    end
                end
                default: state <= BS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spf_regs.sv
module spf_regs
    import spf_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              tx_empty,
    input  logic              tx_full,
    input  logic              tx_push_ok,
    input  logic              rx_empty,
    input  logic              rx_full,
    input  logic [REG_W-1:0]  rx_head,
    input  logic              busy,
    input  logic              done,
    input  logic              tx_act,
    input  logic              rx_act,
    output logic [REG_W-1:0]  cmd_q,
    output xfer_ctl_t         ctl_q,
    output logic              ready_q,
    output logic              txovf_q,
    output logic              rxunf_q,
    output logic              start,
    output logic [CW-1:0]     start_words,
    output logic              tx_push,
    output logic              tx_flush,
    output logic              rx_pop,
    output logic              rx_flush,
    output logic              irq
);
    logic wr_cmd, wr_stat, wr_ctrl, rd_rxf;
    logic ovf_evt, unf_evt;
    logic [REG_W-1:0] stat_word;

    assign wr_cmd   = bus_wr && (bus_addr == OFS_CMD);
    assign wr_stat  = bus_wr && (bus_addr == OFS_STAT);
    assign wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
    assign tx_push  = bus_wr && (bus_addr == OFS_TXF);
    assign rd_rxf   = bus_rd && (bus_addr == OFS_RXF);
    assign rx_pop   = rd_rxf;
    assign tx_flush = wr_stat && bus_wdata[ST_TXFLSH];
    assign rx_flush = wr_stat && bus_wdata[ST_RXFLSH];

    assign ovf_evt  = tx_push && !tx_push_ok && !tx_flush;
    assign unf_evt  = rd_rxf && rx_empty;

    assign start       = wr_ctrl && !busy && bus_wdata[31];
    assign start_words = CW'(burst_len(bus_wdata[15:0], DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            ctl_q   <= '0;
            ready_q <= 1'b0;
            txovf_q <= 1'b0;
            rxunf_q <= 1'b0;
        end else begin
            if (wr_cmd) cmd_q <= bus_wdata;

            if (done)                 ctl_q.go <= 1'b0;
            else if (wr_ctrl && !busy) ctl_q <= word_to_ctl(bus_wdata);

            if (done)                                  ready_q <= 1'b1;
            else if (wr_stat && bus_wdata[ST_READY])   ready_q <= 1'b0;

            if (ovf_evt)                               txovf_q <= 1'b1;
            else if (wr_stat && bus_wdata[ST_TXOVF])   txovf_q <= 1'b0;

            if (unf_evt)                               rxunf_q <= 1'b1;
            else if (wr_stat && bus_wdata[ST_RXUNF])   rxunf_q <= 1'b0;
        end
    end

    always_comb begin
        stat_word            = '0;
        stat_word[ST_BUSY]   = busy;
        stat_word[ST_READY]  = ready_q;
        stat_word[ST_RXUNF]  = rxunf_q;
        stat_word[ST_TXOVF]  = txovf_q;
        stat_word[ST_RXEMP]  = rx_empty;
        stat_word[ST_RXFUL]  = rx_full;
        stat_word[ST_TXEMP]  = tx_empty;
        stat_word[ST_TXFUL]  = tx_full;
    end

    always_comb begin
        case (bus_addr)
            OFS_CMD:  bus_rdata = cmd_q;
            OFS_STAT: bus_rdata = stat_word;
            OFS_CTRL: bus_rdata = ctl_to_word(ctl_q);
            OFS_RXF:  bus_rdata = rx_empty ? '0 : rx_head;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = ready_q && ((ctl_q.ie_tx && tx_act) || (ctl_q.ie_rx && rx_act));

endmodule

// File: rtl/spf_frontend.sv
module spf_frontend
    import spf_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 4,
    localparam int unsigned CW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [REG_W-1:0]  eng_cmd,
    output logic              eng_load,
    output logic [REG_W-1:0]  eng_tx_word,
    input  logic              eng_done,
    input  logic [REG_W-1:0]  eng_rx_word,
    output logic              irq
);
    logic             tx_push, tx_pop, tx_flush, tx_empty, tx_full, tx_push_ok;
    logic [REG_W-1:0] tx_head;
    logic             rx_push, rx_pop, rx_flush, rx_empty, rx_full, rx_push_ok;
    logic [REG_W-1:0] rx_head, rx_word;
    logic             busy, done, start, tx_act, rx_act;
    logic             ready_q, txovf_q, rxunf_q;
    logic [CW-1:0]    start_words;
    logic [REG_W-1:0] cmd_q;
    xfer_ctl_t        ctl_q;

    assign eng_cmd = cmd_q;

    spf_fifo #(.WIDTH(REG_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(tx_flush),
        .push(tx_push), .push_data(bus_wdata), .pop(tx_pop),
        .head(tx_head), .empty(tx_empty), .full(tx_full), .push_ok(tx_push_ok)
    );

    spf_fifo #(.WIDTH(REG_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(rx_flush),
        .push(rx_push), .push_data(rx_word), .pop(rx_pop),
        .head(rx_head), .empty(rx_empty), .full(rx_full), .push_ok(rx_push_ok)
    );

    spf_burst #(.WIDTH(REG_W), .DEPTH(FIFO_DEPTH)) u_seq (
        .clk(clk), .rst(rst), .start(start), .start_words(start_words),
        .tx_sel(cmd_q[CMD_TXDIR]), .rx_sel(cmd_q[CMD_RXDIR]),
        .tx_empty(tx_empty), .tx_head(tx_head),
        .eng_done(eng_done), .eng_rx_word(eng_rx_word),
        .busy(busy), .done(done), .tx_pop(tx_pop), .rx_push(rx_push),
        .rx_word(rx_word), .eng_load(eng_load), .eng_tx_word(eng_tx_word),
        .tx_act(tx_act), .rx_act(rx_act)
    );

    spf_regs #(.DEPTH(FIFO_DEPTH)) u_regs (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_empty(tx_empty), .tx_full(tx_full), .tx_push_ok(tx_push_ok),
        .rx_empty(rx_empty), .rx_full(rx_full), .rx_head(rx_head),
        .busy(busy), .done(done), .tx_act(tx_act), .rx_act(rx_act),
        .cmd_q(cmd_q), .ctl_q(ctl_q), .ready_q(ready_q),
        .txovf_q(txovf_q), .rxunf_q(rxunf_q),
        .start(start), .start_words(start_words),
        .tx_push(tx_push), .tx_flush(tx_flush),
        .rx_pop(rx_pop), .rx_flush(rx_flush), .irq(irq)
    );

endmodule

// File: rtl/spf_checker.sv
module spf_checker (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic ready_q,
    input logic txovf_q,
    input logic rxunf_q,
    input logic irq,
    input logic ctl_go,
    input logic eng_load,
    input logic tx_push,
    input logic tx_full,
    input logic tx_pop,
    input logic tx_flush,
    input logic rx_pop,
    input logic rx_empty,
    input logic bus_wr,
    input logic [7:0] bus_addr,
    input logic [31:0] ctl_word
);
    assert_load_in_burst_R4: assert property (@(posedge clk) disable iff (rst)
        eng_load |-> busy);

    assert_irq_needs_ready_R6: assert property (@(posedge clk) disable iff (rst)
        irq |-> ready_q);

    assert_overflow_flag_R2: assert property (@(posedge clk) disable iff (rst)
        (tx_push && tx_full && !tx_pop && !tx_flush) |=> txovf_q);

    assert_underflow_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && rx_empty) |=> rxunf_q);

    assert_finish_state_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (ready_q && !ctl_go));

    assert_ctrl_locked_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && bus_wr && bus_addr == 8'h0C) |=>
            (ctl_word[30:0] == $past(ctl_word[30:0])));
endmodule

bind spf_frontend spf_checker u_chk (
    .clk(clk), .rst(rst), .busy(busy), .ready_q(ready_q),
    .txovf_q(txovf_q), .rxunf_q(rxunf_q), .irq(irq), .ctl_go(ctl_q.go),
    .eng_load(eng_load), .tx_push(tx_push), .tx_full(tx_full),
    .tx_pop(tx_pop), .tx_flush(tx_flush), .rx_pop(rx_pop),
    .rx_empty(rx_empty), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .ctl_word(spf_pkg::ctl_to_word(ctl_q))
);

// File: tb/spf_frontend_tb.sv
`timescale 1ns/100ps
module spf_frontend_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, eng_cmd, eng_tx_word;
    logic        eng_load, irq;
    logic        eng_done = 1'b0;
    logic [31:0] eng_rx_word = '0;

    int nvec = 0, nfail = 0;
    int eng_lat = 1;
    logic [31:0] seen_tx[$];
    logic [31:0] sent_rx[$];

    always #2 clk = ~clk;

    spf_frontend dut_i (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1 bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
        @(posedge clk); #1 bus_rd = 0;
    endtask

    function automatic logic [31:0] ctlw(input bit go, input bit ierx, input bit ietx, input logic [15:0] c);
        return {go, 3'b0, ierx, ietx, 10'b0, c};
    endfunction

    // engine model: answers every load after eng_lat extra cycles
    initial begin
        forever begin
            @(negedge clk);
            eng_done = 0;
            if (eng_load) begin
                seen_tx.push_back(eng_tx_word);
                repeat (eng_lat + 1) @(negedge clk);
                eng_rx_word = $urandom;
                sent_rx.push_back(eng_rx_word);
                eng_done = 1;
            end
        end
    end

    task automatic wait_idle(output logic [31:0] st, input bit drain, ref logic [31:0] got[$]);
        logic [31:0] d;
        int guard = 0;
        do begin
            rd(8'h04, st);
            if (drain && !st[25]) begin rd(8'h20, d); got.push_back(d); end
            guard++;
        end while (st[31] && guard < 2000);
    endtask

    task automatic run_burst(input int n, input bit txs, input bit rxs, input bit ietx, input bit ierx,
                             input bit drain);
        logic [31:0] st, d, w;
        logic [31:0] exp_tx[$];
        logic [31:0] got[$];
        seen_tx.delete(); sent_rx.delete();
        wr(8'h00, {16'b0, txs, rxs, 14'b0});
        for (int i = 0; i < n; i++) begin
            w = $urandom;
            if (txs) begin wr(8'h10, w); exp_tx.push_back(w); end
            else exp_tx.push_back(32'h0);
        end
        wr(8'h0C, ctlw(1, ierx, ietx, 16'(n - 1)));
        wait_idle(st, drain, got);
        chk(st[30] && !st[31], "R5 ready/busy", st, 32'h4000_0000);
        chk(irq == ((ietx && txs) || (ierx && rxs)), "R6 irq", {31'b0, irq}, {31'b0, (ietx && txs) || (ierx && rxs)});
        rd(8'h0C, d);
        chk(d[31] == 0, "R5 go cleared", d, d & 32'h7fff_ffff);
        chk(seen_tx.size() == n, "R4 word count", seen_tx.size(), n);
        for (int i = 0; i < n && i < seen_tx.size(); i++)
            chk(seen_tx[i] == exp_tx[i], txs ? "R2 tx order" : "R9 zero words", seen_tx[i], exp_tx[i]);
        forever begin
            rd(8'h04, st);
            if (st[25]) break;
            rd(8'h20, d); got.push_back(d);
        end
        if (rxs) begin
            chk(got.size() == n, "R3 rx count", got.size(), n);
            for (int i = 0; i < n && i < got.size(); i++)
                chk(got[i] == sent_rx[i], "R3 rx order", got[i], sent_rx[i]);
        end else
            chk(got.size() == 0, "R9 rx discarded", got.size(), 0);
        rd(8'h20, d);
        chk(d == 0, "R3 empty read zero", d, 0);
        rd(8'h04, st);
        chk(st[27], "R3 underflow flag", st, st | 32'h0800_0000);
        wr(8'h04, 32'h4C00_0000);
        rd(8'h04, st);
        chk(st[30:26] == 0, "R7 w1c", st, st & 32'h83ff_ffff);
        chk(irq == 0, "R6 irq dropped", irq, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog timeout actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        logic [31:0] d, st;
        logic [31:0] dummy[$];
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // reset state
        rd(8'h04, d); chk(d == 32'h0280_0000, "R1 status reset", d, 32'h0280_0000);
        rd(8'h00, d); chk(d == 0, "R1 cmd reset", d, 0);
        rd(8'h0C, d); chk(d == 0, "R1 ctrl reset", d, 0);
        chk(irq == 0, "R1 irq reset", irq, 0);

        // ctrl readback without start
        wr(8'h0C, 32'h4C15_0005);
        rd(8'h0C, d); chk(d == 32'h0C15_0005, "R1 ctrl fields", d, 32'h0C15_0005);
        rd(8'h04, d); chk(d[31] == 0, "R4 no start without go", d, 0);

        // directed bursts
        eng_lat = 0;
        run_burst(1, 1, 1, 1, 0, 0);
        run_burst(4, 1, 1, 0, 1, 1);
        run_burst(3, 0, 1, 0, 1, 0);
        run_burst(2, 1, 0, 0, 1, 0);   // irq enable mismatched with direction

        // overflow and FIFO flags
        wr(8'h00, 32'h0000_8000);
        for (int i = 0; i < 4; i++) wr(8'h10, 32'hA0 + i);
        rd(8'h04, d);
        chk(d[22] && !d[23], "R12 tx full", d, 32'h0040_0000);
        wr(8'h10, 32'hDEAD);
        rd(8'h04, d); chk(d[26], "R2 overflow flag", d, d | 32'h0400_0000);
        seen_tx.delete();
        wr(8'h0C, ctlw(1, 0, 0, 16'd9));   // clamped to 4
        wait_idle(st, 0, dummy);
        chk(seen_tx.size() == 4, "R4 clamp to depth", seen_tx.size(), 4);
        for (int i = 0; i < 4 && i < seen_tx.size(); i++)
            chk(seen_tx[i] == 32'hA0 + i, "R2 overflow dropped", seen_tx[i], 32'hA0 + i);
        wr(8'h04, 32'h0000_0000);
        rd(8'h04, d); chk(d[30] && d[26], "R7 zero write keeps", d, d | 32'h4400_0000);
        wr(8'h04, 32'h4400_0000);

        // rx full flag, then flush
        wr(8'h00, 32'h0000_4000);
        wr(8'h0C, ctlw(1, 0, 0, 16'd3));
        wait_idle(st, 0, dummy);
        rd(8'h04, d); chk(d[24] && !d[25], "R12 rx full", d, 32'h0100_0000);
        wr(8'h04, 32'h5000_0000);
        rd(8'h04, d); chk(d[25] && !d[24], "R8 rx flush", d, 32'h0200_0000);

        // tx fifo untouched when tx not selected, then flush
        wr(8'h10, 32'h1234);
        wr(8'h0C, ctlw(1, 0, 0, 16'd0));
        wait_idle(st, 0, dummy);
        rd(8'h04, d); chk(!d[23], "R9 tx not popped", d, d & ~32'h0080_0000);
        wr(8'h04, 32'h6000_0000);
        rd(8'h04, d); chk(d[23], "R8 tx flush", d, d | 32'h0080_0000);
        wr(8'h04, 32'h1000_0000);

        // stall with empty tx fifo
        wr(8'h00, 32'h0000_8000);
        seen_tx.delete();
        wr(8'h0C, ctlw(1, 0, 0, 16'd0));
        repeat (10) @(posedge clk);
        rd(8'h04, d);
        chk(d[31] && seen_tx.size() == 0, "R10 stall", seen_tx.size(), 0);
        wr(8'h10, 32'h00C0_FFEE);
        wait_idle(st, 0, dummy);
        chk(seen_tx.size() == 1 && seen_tx[0] == 32'h00C0_FFEE, "R10 resume", seen_tx.size() > 0 ? seen_tx[0] : 0, 32'h00C0_FFEE);
        wr(8'h04, 32'h4000_0000);

        // control write during burst ignored
        eng_lat = 20;
        wr(8'h10, 1); wr(8'h10, 2);
        wr(8'h0C, ctlw(1, 0, 1, 16'd1));
        wr(8'h0C, ctlw(1, 1, 0, 16'd3));
        wait_idle(st, 0, dummy);
        rd(8'h0C, d); chk(d == ctlw(0, 0, 1, 16'd1), "R11 busy write ignored", d, ctlw(0, 0, 1, 16'd1));
        wr(8'h04, 32'h4000_0000);

        // random bursts with concurrent draining
        for (int k = 0; k < 30; k++) begin
            eng_lat = $urandom_range(0, 5);
            run_burst($urandom_range(1, 4), ($urandom_range(0, 3) != 0), ($urandom_range(0, 3) != 0),
                      $urandom_range(0, 1), $urandom_range(0, 1), 1);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule